// File: doc/BRIEF.md
# DDR Burst Access Command Sequencer

This block converts a single user access request into the row and column command sequence that a DDR SDRAM expects for one burst. A request carries the direction (read or write), a bank, a row, a starting column, a burst-length selector and an auto-precharge flag. The sequencer opens the row, waits a fixed number of row-to-column cycles, issues the column command and then counts the burst out. It ends the access with a one-cycle completion pulse.

Command and address outputs are registered, so the memory samples them on the rising edge of its clock. The block keeps an open/closed flag and a precharge timer for each bank. A request to a bank whose row is still open first closes that row. A request to a bank that is still precharging waits until the precharge time has run out. Data capture, strobe generation, refresh and power management belong to other blocks.

Top module: `ddr_burst_seq`

## Requirements
- R1: After reset, `reqReady` is 1, `done` is 0 and the command is NOP ({csN,rasN,casN,weN} = 0111) with `ba` and `addr` at zero.
- R2: A request is taken only on a cycle where `reqValid` and `reqReady` are both 1, and `reqReady` is 1 only while the sequencer is idle. If the target bank is closed and its precharge time has expired, ACTIVE (0011) appears in the cycle after acceptance, with `ba` = bank and `addr` = row.
- R3: The command encodings on {csN,rasN,casN,weN} are NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100 and PRECHARGE 0010, and nothing else is ever driven. On every NOP cycle, `ba` and `addr` are zero.
- R4: READ (0101, `reqWrite`=0) or WRITE (0100, `reqWrite`=1) appears exactly T_RCD cycles after ACTIVE. `ba` repeats the bank, `addr[9:0]` carries the column, `addr[10]` carries the auto-precharge flag, and `addr[12:11]` is zero.
- R5: `reqBurst` selects the burst length: 0 gives 2, 1 gives 4, and 2 or 3 gives 8. When the column command appears in cycle c, `done` is high for exactly the one cycle c + length/2 + 1.
- R6: Without auto-precharge, the row stays open. The next access to that bank starts with PRECHARGE (0010, `ba` = bank, `addr` = 0) in the cycle after acceptance, and its ACTIVE follows T_RP cycles after that PRECHARGE.
- R7: With auto-precharge, the bank is treated as closed once the access ends. ACTIVE to that bank never appears earlier than T_RP cycles after its `done` cycle. Other banks are not delayed by this.
- R8: Request inputs presented while `reqReady` is 0 are ignored: they produce no command and do not change later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are launched on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle, request can be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBank | input | BA_W (2) | Target bank |
| reqRow | input | ADDR_W (13) | Row to open |
| reqCol | input | COL_W (10) | Starting column |
| reqAutoPre | input | 1 | Close the row automatically after the burst |
| reqBurst | input | 2 | Burst length selector |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | BA_W (2) | Bank address |
| addr | output | ADDR_W (13) | Row / column address |
| done | output | 1 | One-cycle access completion pulse |

## Verification
The hardest situation to reach is a request to a bank that is closed but still inside its precharge window. In that case the sequencer has to hold in a wait state without issuing anything. The stimulus reaches it by sending an auto-precharge access and then, in the first idle cycle, a second request to the same bank. It also reaches the open-row case by sending a non-auto-precharge access followed by another access to that bank. A reference model of the per-bank open flags and earliest ACTIVE cycles predicts the cycle number of every command, so the scoreboard checks the exact spacing.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  // {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010
  } ddrCmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_RP,
    ST_WAIT_RCD,
    ST_BURST,
    ST_DONE
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;
    logic issuePre;
    logic issueAct;
    logic issueCol;
    logic closeAuto;
  } seqStrobe_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import ddr_seq_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             selOpen,
  input  logic             selActOk,
  input  logic [CNT_W-1:0] burstHalf,
  output logic             reqReady,
  output logic             done,
  output seqStrobe_t       strobe
);

  localparam logic [CNT_W-1:0] RCD_LOAD = CNT_W'(T_RCD - 1);

  seqState_t        st, stNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_comb begin
    stNext  = st;
    cntNext = cnt;
    strobe  = '0;
    case (st)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          if (selOpen) begin
            strobe.issuePre = 1'b1;
            stNext          = ST_WAIT_RP;
          end else if (selActOk) begin
            strobe.issueAct = 1'b1;
            stNext          = ST_WAIT_RCD;
            cntNext         = RCD_LOAD;
          end else begin
            stNext = ST_WAIT_RP;
          end
        end
      end
      ST_WAIT_RP: begin
        if (selActOk) begin
          strobe.issueAct = 1'b1;
          stNext          = ST_WAIT_RCD;
          cntNext         = RCD_LOAD;
        end
      end
      ST_WAIT_RCD: begin
        if (cnt == '0) begin
          strobe.issueCol = 1'b1;
          stNext          = ST_BURST;
          cntNext         = burstHalf;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_BURST: begin
        if (cnt == '0) begin
          strobe.closeAuto = 1'b1;
          stNext           = ST_DONE;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st  <= stNext;
      cnt <= cntNext;
    end
  end

  assign reqReady = (st == ST_IDLE);
  assign done     = (st == ST_DONE);

  // R5: completion is a single-cycle pulse
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: an accepted request leaves the idle state at once
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

// File: rtl/seq_dpath.sv
module seq_dpath
  import ddr_seq_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 13,
  parameter int COL_W  = 10,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              reqReady,
  input  logic              reqWrite,
  input  logic [BA_W-1:0]   reqBank,
  input  logic [ADDR_W-1:0] reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              reqAutoPre,
  input  logic [1:0]        reqBurst,
  output logic              selOpen,
  output logic              selActOk,
  output logic [CNT_W-1:0]  burstHalf,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);

  localparam int NB     = 1 << BA_W;
  localparam int RP_W   = $clog2(T_RP + 1);
  localparam int AP_BIT = 10;
  localparam int SA_W   = $clog2(T_RCD + 2);

  // held request
  logic              hWrite, hAp;
  logic [BA_W-1:0]   hBank;
  logic [ADDR_W-1:0] hRow;
  logic [COL_W-1:0]  hCol;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hWrite    <= 1'b0;
      hAp       <= 1'b0;
      hBank     <= '0;
      hRow      <= '0;
      hCol      <= '0;
      burstHalf <= '0;
    end else if (strobe.capture) begin
      hWrite <= reqWrite;
      hAp    <= reqAutoPre;
      hBank  <= reqBank;
      hRow   <= reqRow;
      hCol   <= reqCol;
      case (reqBurst)
        2'd0:    burstHalf <= CNT_W'(1);
        2'd1:    burstHalf <= CNT_W'(2);
        default: burstHalf <= CNT_W'(4);
      endcase
    end
  end

  logic [BA_W-1:0]   selBank;
  logic [ADDR_W-1:0] selRow;
  assign selBank = reqReady ? reqBank : hBank;
  assign selRow  = reqReady ? reqRow  : hRow;

  // per-bank row state and precharge timers
  logic [NB-1:0]   bankOpen;
  logic [NB-1:0]   bankActOk;
  logic [RP_W-1:0] bankTimer [NB];

  for (genvar i = 0; i < NB; i++) begin : g_bank
    logic hitSel, hitHeld;
    assign hitSel  = (selBank == BA_W'(i));
    assign hitHeld = (hBank == BA_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        bankOpen[i]  <= 1'b0;
        bankTimer[i] <= '0;
      end else begin
        if (strobe.issueAct && hitSel)
          bankOpen[i] <= 1'b1;
        else if ((strobe.issuePre && hitSel) || (strobe.closeAuto && hAp && hitHeld))
          bankOpen[i] <= 1'b0;

        if ((strobe.issuePre && hitSel) || (strobe.closeAuto && hAp && hitHeld))
          bankTimer[i] <= RP_W'(T_RP);
        else if (bankTimer[i] != '0)
          bankTimer[i] <= bankTimer[i] - 1'b1;
      end
    end

    assign bankActOk[i] = (bankTimer[i] <= RP_W'(1));
  end

  assign selOpen  = bankOpen[selBank];
  assign selActOk = bankActOk[selBank];

  // column address with auto-precharge flag
  logic [ADDR_W-1:0] colAddr;
  always_comb begin
    colAddr                = '0;
    colAddr[COL_W-1:0]     = hCol;
    colAddr[AP_BIT]        = hAp;
  end

  // registered command outputs
  ddrCmd_t           cmdQ;
  logic [BA_W-1:0]   baQ;
  logic [ADDR_W-1:0] addrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ  <= CMD_NOP;
      baQ   <= '0;
      addrQ <= '0;
    end else if (strobe.issuePre) begin
      cmdQ  <= CMD_PRE;
      baQ   <= selBank;
      addrQ <= '0;
    end else if (strobe.issueAct) begin
      cmdQ  <= CMD_ACT;
      baQ   <= selBank;
      addrQ <= selRow;
    end else if (strobe.issueCol) begin
      cmdQ  <= hWrite ? CMD_WR : CMD_RD;
      baQ   <= hBank;
      addrQ <= colAddr;
    end else begin
      cmdQ  <= CMD_NOP;
      baQ   <= '0;
      addrQ <= '0;
    end
  end

  assign {csN, rasN, casN, weN} = cmdQ;
  assign ba   = baQ;
  assign addr = addrQ;

  // cycles since the last ACTIVE left the block (checker counter)
  logic [SA_W-1:0] sinceAct;
  always_ff @(posedge clk) begin
    if (!rstN)                  sinceAct <= '0;
    else if (cmdQ == CMD_ACT)   sinceAct <= SA_W'(1);
    else if (sinceAct != '1)    sinceAct <= sinceAct + 1'b1;
  end

  // R3: only the five legal encodings reach the pins
  a_r3_cmd_legal: assert property (@(posedge clk) disable iff (!rstN)
    cmdQ inside {CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE});

  // R4: column command lands T_RCD cycles after ACTIVE
  a_r4_rcd_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_RD || cmdQ == CMD_WR) |-> (sinceAct == SA_W'(T_RCD)));

  // R7: ACTIVE only once the bank's precharge time has run out
  a_r7_act_after_rp: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_ACT) |-> (bankTimer[baQ] == '0));

  // R6: a bank receives no ACTIVE while its row is still open
  a_r6_act_closed: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issueAct) |-> !bankOpen[selBank]);

endmodule

// File: rtl/ddr_burst_seq.sv
module ddr_burst_seq
  import ddr_seq_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 13,
  parameter int COL_W  = 10,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [BA_W-1:0]   reqBank,
  input  logic [ADDR_W-1:0] reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              reqAutoPre,
  input  logic [1:0]        reqBurst,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);

  localparam int CNT_W = $clog2(T_RCD + 5);

  seqStrobe_t       strobe;
  logic             selOpen, selActOk;
  logic [CNT_W-1:0] burstHalf;

  seq_ctrl #(
    .T_RCD(T_RCD),
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .selOpen  (selOpen),
    .selActOk (selActOk),
    .burstHalf(burstHalf),
    .reqReady (reqReady),
    .done     (done),
    .strobe   (strobe)
  );

  seq_dpath #(
    .BA_W  (BA_W),
    .ADDR_W(ADDR_W),
    .COL_W (COL_W),
    .T_RCD (T_RCD),
    .T_RP  (T_RP),
    .CNT_W (CNT_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqReady  (reqReady),
    .reqWrite  (reqWrite),
    .reqBank   (reqBank),
    .reqRow    (reqRow),
    .reqCol    (reqCol),
    .reqAutoPre(reqAutoPre),
    .reqBurst  (reqBurst),
    .selOpen   (selOpen),
    .selActOk  (selActOk),
    .burstHalf (burstHalf),
    .csN       (csN),
    .rasN      (rasN),
    .casN      (casN),
    .weN       (weN),
    .ba        (ba),
    .addr      (addr)
  );

endmodule

// File: tb/ddr_burst_seq_test.sv
module ddr_burst_seq_test;

  localparam int T_RCD = 3;
  localparam int T_RP  = 4;
  localparam logic [3:0] K_NOP  = 4'b0111;
  localparam logic [3:0] K_ACT  = 4'b0011;
  localparam logic [3:0] K_RD   = 4'b0101;
  localparam logic [3:0] K_WR   = 4'b0100;
  localparam logic [3:0] K_PRE  = 4'b0010;
  localparam logic [3:0] K_DONE = 4'b1111;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqBank = '0;
  logic [12:0] reqRow = '0;
  logic [9:0]  reqCol = '0;
  logic        reqAutoPre = 1'b0;
  logic [1:0]  reqBurst = '0;
  logic        csN, rasN, casN, weN, done;
  logic [1:0]  ba;
  logic [12:0] addr;

  ddr_burst_seq #(.T_RCD(T_RCD), .T_RP(T_RP)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .reqAutoPre(reqAutoPre), .reqBurst(reqBurst),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .ba(ba), .addr(addr),
    .done(done)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [3:0]  kind;
    int          at;
    logic [1:0]  b;
    logic [12:0] a;
    string       req;
  } item_t;

  item_t expQ[$];
  int    nChecks = 0;
  int    nFails  = 0;
  bit    monOn   = 1'b0;
  bit    finished = 1'b0;

  // bench model of bank state
  bit openB[4];
  int allowed[4];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] k, input int at, input logic [1:0] b,
                      input logic [12:0] a, input string req);
    item_t it;
    it.kind = k; it.at = at; it.b = b; it.a = a; it.req = req;
    expQ.push_back(it);
  endtask

  // driver: waits for ready, presents the request, predicts the commands
  task automatic doReq(input bit wr, input int b, input int row, input int col,
                       input bit ap, input int bsel, input bit spam);
    int t, act, c, d, half;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqWrite = wr; reqBank = 2'(b); reqRow = 13'(row); reqCol = 10'(col);
    reqAutoPre = ap; reqBurst = 2'(bsel); reqValid = 1'b1;
    t = cyc;
    act = t + 1;
    if (openB[b]) begin
      push(K_PRE, t + 1, 2'(b), 13'd0, "R6");
      allowed[b] = t + 1 + T_RP;
      openB[b] = 1'b0;
    end
    if (allowed[b] > act) act = allowed[b];
    push(K_ACT, act, 2'(b), 13'(row), (allowed[b] > t + 1) ? "R7" : "R2");
    openB[b] = 1'b1;
    c = act + T_RCD;
    push(wr ? K_WR : K_RD, c, 2'(b), 13'(col) | (13'(ap) << 10), "R4");
    half = (bsel == 0) ? 1 : (bsel == 1) ? 2 : 4;
    d = c + half + 1;
    push(K_DONE, d, 2'd0, 13'd0, "R5");
    if (ap) begin
      openB[b] = 1'b0;
      allowed[b] = d + T_RP;
    end
    @(negedge clk);
    reqValid = 1'b0;
    if (spam) begin
      // R8: junk while busy must be ignored
      forever begin
        if (reqReady) begin
          reqValid = 1'b0;
          break;
        end
        reqValid = 1'b1; reqWrite = ~reqWrite; reqBank = reqBank + 2'd1;
        reqRow = reqRow ^ 13'h155; reqCol = reqCol + 10'd7; reqAutoPre = 1'b1;
        @(negedge clk);
      end
    end
  endtask

  // monitor: compares every command and done pulse with the queue
  always @(negedge clk) begin
    if (monOn) begin
      logic [3:0] k;
      k = {csN, rasN, casN, weN};
      if (k == K_NOP) begin
        check(ba == 2'd0 && addr == 13'd0, "R3", "nop quiet bus", {ba, addr}, 0);
      end
      if (k != K_NOP || done) begin
        logic [3:0] seen;
        seen = done ? K_DONE : k;
        if (done) check(k == K_NOP, "R5", "cmd during done", k, K_NOP);
        if (expQ.size() == 0) begin
          check(1'b0, "R8", "unexpected command", seen, K_NOP);
        end else begin
          item_t e;
          e = expQ.pop_front();
          check(seen == e.kind, e.req, "kind", seen, e.kind);
          check(cyc == e.at, e.req, "cycle", cyc, e.at);
          if (!done) begin
            check(ba == e.b, e.req, "bank", ba, e.b);
            check(addr == e.a, e.req, "addr", addr, e.a);
          end
        end
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin openB[i] = 1'b0; allowed[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(reqReady == 1'b1, "R1", "ready", reqReady, 1);
    check(done == 1'b0, "R1", "done", done, 0);
    check({csN, rasN, casN, weN} == K_NOP, "R1", "cmd", {csN, rasN, casN, weN}, K_NOP);
    check(ba == 2'd0 && addr == 13'd0, "R1", "bus", {ba, addr}, 0);
    monOn = 1'b1;

    doReq(1'b0, 0, 13'h0005, 10'h008, 1'b0, 1, 1'b0);  // R2 read, BL4, row left open
    doReq(1'b1, 1, 13'h1ABC, 10'h3FF, 1'b1, 2, 1'b1);  // R8 junk while busy, BL8, R7
    doReq(1'b0, 0, 13'h0777, 10'h010, 1'b1, 0, 1'b0);  // R6 open row closed first, BL2
    doReq(1'b1, 0, 13'h0042, 10'h001, 1'b0, 3, 1'b0);  // R7 waits for precharge, sel 3 = BL8
    doReq(1'b0, 1, 13'h1FFF, 10'h2AA, 1'b0, 1, 1'b0);  // bank 1 long closed
    doReq(1'b1, 2, 13'h0100, 10'h155, 1'b1, 2, 1'b0);  // auto-precharge bank 2
    doReq(1'b0, 3, 13'h0200, 10'h000, 1'b1, 0, 1'b0);  // R7 other bank not delayed
    doReq(1'b0, 2, 13'h0300, 10'h0F0, 1'b0, 1, 1'b1);  // bank 2 again
    doReq(1'b1, 0, 13'h0001, 10'h3C3, 1'b1, 1, 1'b0);  // R6 bank 0 open from earlier
    doReq(1'b1, 0, 13'h0002, 10'h004, 1'b0, 0, 1'b0);  // R7 back to back on same bank

    while (expQ.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
    check(expQ.size() == 0, "R8", "leftover expected items", expQ.size(), 0);
    check(reqReady == 1'b1, "R2", "ready at end", reqReady, 1);
    finishRun();
  end

endmodule